// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Controller

This block is the hazard and forwarding control for an in-order pipeline with eight stages: two fetch stages, decode, two execute stages, two memory stages and write-back. It looks at the destination, write-enable and load flag of each pipeline buffer, the source registers of the instruction in decode and of the instruction in the ID/EX1 buffer, and a redirect flag that decode raises when it resolves a branch or jump. From these it drives hold enables, a no-op insert, a flush for the fetch stages, and the operand selects for the ID/EX1 forwarding muxes. The datapath, memories and register file lie outside the block.

The register file has one port. It can do a read or a write in a cycle, but not both, and write-back takes precedence. ALU results can be forwarded only from the three buffers that come after EX2. A load value can be forwarded only once it reaches MEM2/WB. A register number of NUM_REGS or above marks an operand as unused. Register 0 never counts as a destination. A redirect that arrives while the front of the pipe is held is stored. The flush is then issued in the first cycle in which no hold is active.

When `front_hold` is high and `de_hold` is low, the pipeline must load a no-op into the ID/EX1 buffer. When `bubble` is high, the pipeline must load a no-op into the EX1/EX2 buffer.

Top module: `hz8_ctl`

## Requirements
- R1: A write-back write is a real write when `wb_we` is 1 and `wb_dst` is in 1..NUM_REGS-1. If such a write occurs while either `id_src_a` or `id_src_b` is in 0..NUM_REGS-1, then `front_hold`=1. In that cycle, if no data hazard is present, `de_hold`=0 and `bubble`=0.
- R2: The structural hold does not occur in either of these cases: both decode sources are out of range, or `wb_we`=0.
- R3: If `x1_we`=1 and `x1_dst` equals an in-range ID/EX1 source, then `front_hold`, `de_hold` and `bubble` are all 1. This holds whether or not the EX1/EX2 instruction is a load.
- R4: A load (`*_ld`=1, `*_we`=1) in EX2/MEM1 or in MEM1/MEM2 whose destination matches an in-range ID/EX1 source causes the same stall as R3. A non-load match in those buffers causes no stall.
- R5: `fwd_a` and `fwd_b` use this code: 0 means register file, 1 means EX2/MEM1, 2 means MEM1/MEM2, 3 means MEM2/WB. Each operand takes the youngest matching buffer, in the order EX2/MEM1, MEM1/MEM2, MEM2/WB. The two operands are selected independently.
- R6: A load in EX2/MEM1 or MEM1/MEM2 is never selected. If the youngest match for an operand is such a load, that operand's select is 0 and the stall of R4 is raised. A load in MEM2/WB can be forwarded (code 3).
- R7: A source register of NUM_REGS or above never causes a structural hold, a data stall or a non-zero select. This holds even when its low bits equal a destination.
- R8: A destination of register 0 never causes a structural hold, a data stall or a forward.
- R9: If `redirect`=1 and no hold is active, `flush_fetch`=1 in the same cycle.
- R10: `flush_fetch` is 0 in every cycle in which `front_hold` is 1. A redirect seen during a hold produces exactly one `flush_fetch` pulse, in the first cycle without a hold.
- R11: The reset is synchronous and active low. It clears any stored redirect. After reset, with quiet inputs, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_src_a | input | REG_W | First source of the instruction in decode |
| id_src_b | input | REG_W | Second source of the instruction in decode |
| de_src_a | input | REG_W | First source of the instruction in ID/EX1 |
| de_src_b | input | REG_W | Second source of the instruction in ID/EX1 |
| x1_dst | input | REG_W | Destination in EX1/EX2 |
| x1_we | input | 1 | EX1/EX2 writes a register |
| x2_dst | input | REG_W | Destination in EX2/MEM1 |
| x2_we | input | 1 | EX2/MEM1 writes a register |
| x2_ld | input | 1 | EX2/MEM1 holds a load |
| m1_dst | input | REG_W | Destination in MEM1/MEM2 |
| m1_we | input | 1 | MEM1/MEM2 writes a register |
| m1_ld | input | 1 | MEM1/MEM2 holds a load |
| wb_dst | input | REG_W | Destination in MEM2/WB |
| wb_we | input | 1 | MEM2/WB writes a register |
| redirect | input | 1 | Decode resolved a control hazard |
| front_hold | output | 1 | Hold IF1, IF2 and decode |
| de_hold | output | 1 | Hold the ID/EX1 buffer |
| bubble | output | 1 | Insert a no-op into EX1/EX2 |
| flush_fetch | output | 1 | Flush IF1 and IF2 |
| fwd_a | output | 2 | Forward select for operand A |
| fwd_b | output | 2 | Forward select for operand B |

## Verification
The bench builds the block with its default parameters: REG_W of 8 and NUM_REGS of 32. With these values, the register codes from 32 to 255 are available as markers for unused operands. Codes such as 37 and 33 alias live registers in their low five bits, which tests that range checks are not done by truncation. The default width also fits the three-buffer priority cases and the case of a load shadowing an older ALU result. Redirect cases cover a stall lasting one cycle and a stall lasting several cycles, and a reset that arrives while a flush is pending.

// File: rtl/hz_pkg.sv
// Shared types for the eight-stage hazard controller.
// Assumes: select codes are decoded by the ID/EX1 operand muxes.
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF = 2'd0,
        FWD_X2 = 2'd1,
        FWD_M1 = 2'd2,
        FWD_WB = 2'd3
    } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
// Forward select for one ID/EX1 operand: youngest matching buffer wins,
// loads still in flight before MEM2/WB are never picked.
// Assumes: the data-stall logic covers the case where the youngest match is a load.
module hz_fwd_pick #(
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] x2_dst,
    input  logic             x2_we,
    input  logic             x2_ld,
    input  logic [REG_W-1:0] m1_dst,
    input  logic             m1_we,
    input  logic             m1_ld,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_we,
    output hz_pkg::fwd_sel_e sel
);
    import hz_pkg::*;

    localparam logic [REG_W-1:0] REG_LIM = REG_W'(NUM_REGS);

    logic src_ok, hit_x2, hit_m1, hit_wb;

    // Match each forwarding buffer against the operand.
    always_comb begin
        src_ok = (src < REG_LIM);
        hit_x2 = src_ok && x2_we && (x2_dst != '0) && (x2_dst < REG_LIM) && (x2_dst == src);
        hit_m1 = src_ok && m1_we && (m1_dst != '0) && (m1_dst < REG_LIM) && (m1_dst == src);
        hit_wb = src_ok && wb_we && (wb_dst != '0) && (wb_dst < REG_LIM) && (wb_dst == src);
    end

    // Priority pick: youngest match decides; an in-flight load yields no forward.
    always_comb begin
        if (hit_x2)      sel = x2_ld ? FWD_RF : FWD_X2;
        else if (hit_m1) sel = m1_ld ? FWD_RF : FWD_M1;
        else if (hit_wb) sel = FWD_WB;
        else             sel = FWD_RF;
    end

    a_r6_no_load_x2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_X2) |-> !x2_ld);
    a_r6_no_load_m1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_M1) |-> !m1_ld);
    a_r7_unused_src: assert property (@(posedge clk) disable iff (!rst_n)
        (src >= REG_LIM) |-> (sel == FWD_RF));
endmodule

// File: rtl/hz_data_chk.sv
// Data-stall detection for the ID/EX1 instruction: any EX1/EX2 writer, or a
// load in EX2/MEM1 or MEM1/MEM2, matching a used source forces a stall.
// Assumes: EX1/EX2 has no forwarding path, loads forward only from MEM2/WB.
module hz_data_chk #(
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 32,
    parameter int NUM_SRC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] x1_dst,
    input  logic             x1_we,
    input  logic [REG_W-1:0] x2_dst,
    input  logic             x2_we,
    input  logic             x2_ld,
    input  logic [REG_W-1:0] m1_dst,
    input  logic             m1_we,
    input  logic             m1_ld,
    output logic             stall
);
    localparam logic [REG_W-1:0] REG_LIM = REG_W'(NUM_REGS);

    logic [REG_W-1:0]   srcs [NUM_SRC];
    logic [NUM_SRC-1:0] hit;
    logic               x1_real, x2_ldr, m1_ldr;

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    // Qualify the producers that cannot be forwarded yet.
    always_comb begin
        x1_real = x1_we && (x1_dst != '0) && (x1_dst < REG_LIM);
        x2_ldr  = x2_we && x2_ld && (x2_dst != '0) && (x2_dst < REG_LIM);
        m1_ldr  = m1_we && m1_ld && (m1_dst != '0) && (m1_dst < REG_LIM);
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // Per-operand hazard against the unforwardable producers.
        always_comb begin
            hit[g] = (srcs[g] < REG_LIM) &&
                     ((x1_real && (x1_dst == srcs[g])) ||
                      (x2_ldr  && (x2_dst == srcs[g])) ||
                      (m1_ldr  && (m1_dst == srcs[g])));
        end
    end

    assign stall = |hit;

    a_r4_stall_source: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !x1_we && !x2_ld) |-> (m1_ld && m1_we));
    a_r8_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (x1_dst == '0 && !x2_we && !m1_we) |-> !stall);
endmodule

// File: rtl/hz_flush_ctl.sv
// Fetch-flush control: a redirect flushes at once unless the front is held;
// a redirect seen under hold is kept and released when the hold drops.
// Assumes: hold already includes both structural and data stalls.
module hz_flush_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic redirect,
    input  logic hold,
    output logic flush
);
    logic pend, want;

    assign want  = redirect | pend;
    assign flush = want & ~hold;

    // Keep a redirect pending while the front is held.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= want & hold;
    end

    a_r10_no_flush_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !flush);
    a_r10_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && hold) |=> (hold || flush));
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !redirect) |=> (!flush || redirect));
endmodule

// File: rtl/hz8_ctl.sv
// Hazard controller for an eight-stage in-order pipeline. Combines the
// single-port register-file conflict, the data-stall check, the per-operand
// forward selects and the fetch-flush control.
// Assumes: front_hold without de_hold means the pipe loads a no-op into ID/EX1.
module hz8_ctl #(
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic [REG_W-1:0] de_src_a,
    input  logic [REG_W-1:0] de_src_b,
    input  logic [REG_W-1:0] x1_dst,
    input  logic             x1_we,
    input  logic [REG_W-1:0] x2_dst,
    input  logic             x2_we,
    input  logic             x2_ld,
    input  logic [REG_W-1:0] m1_dst,
    input  logic             m1_we,
    input  logic             m1_ld,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_we,
    input  logic             redirect,
    output logic             front_hold,
    output logic             de_hold,
    output logic             bubble,
    output logic             flush_fetch,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b
);
    import hz_pkg::*;

    localparam int NUM_OPS = 2;
    localparam logic [REG_W-1:0] REG_LIM = REG_W'(NUM_REGS);

    logic [REG_W-1:0] de_src [NUM_OPS];
    fwd_sel_e         sel    [NUM_OPS];
    logic             wb_real, id_reads, port_clash, data_stall;

    assign de_src[0] = de_src_a;
    assign de_src[1] = de_src_b;

    // Single register-file port: write-back beats a decode read.
    always_comb begin
        wb_real    = wb_we && (wb_dst != '0) && (wb_dst < REG_LIM);
        id_reads   = (id_src_a < REG_LIM) || (id_src_b < REG_LIM);
        port_clash = wb_real && id_reads;
    end

    hz_data_chk #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_OPS)) u_data (
        .clk(clk), .rst_n(rst_n),
        .src_a(de_src_a), .src_b(de_src_b),
        .x1_dst(x1_dst), .x1_we(x1_we),
        .x2_dst(x2_dst), .x2_we(x2_we), .x2_ld(x2_ld),
        .m1_dst(m1_dst), .m1_we(m1_we), .m1_ld(m1_ld),
        .stall(data_stall)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_fwd_pick #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_pick (
            .clk(clk), .rst_n(rst_n), .src(de_src[g]),
            .x2_dst(x2_dst), .x2_we(x2_we), .x2_ld(x2_ld),
            .m1_dst(m1_dst), .m1_we(m1_we), .m1_ld(m1_ld),
            .wb_dst(wb_dst), .wb_we(wb_we),
            .sel(sel[g])
        );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    // Hold and bubble outputs.
    assign front_hold = port_clash | data_stall;
    assign de_hold    = data_stall;
    assign bubble     = data_stall;

    hz_flush_ctl u_flush (
        .clk(clk), .rst_n(rst_n),
        .redirect(redirect), .hold(front_hold),
        .flush(flush_fetch)
    );

    a_r1_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_dst != '0 && wb_dst < REG_LIM && id_src_a < REG_LIM) |-> front_hold);
    a_r3_bubble_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (front_hold && de_hold));
    a_r2_idle_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!x1_we && !x2_we && !m1_we && !wb_we) |-> !front_hold);
endmodule

// File: tb/sim_hz8_ctl.sv
// Scoreboard bench: the driver queues expected outputs per cycle, the monitor
// pops and compares them mid-cycle, away from the clock edge.
module sim_hz8_ctl;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst_n;
    logic [7:0] id_src_a, id_src_b, de_src_a, de_src_b;
    logic [7:0] x1_dst, x2_dst, m1_dst, wb_dst;
    logic       x1_we, x2_we, x2_ld, m1_we, m1_ld, wb_we, redirect;
    logic       front_hold, de_hold, bubble, flush_fetch;
    logic [1:0] fwd_a, fwd_b;

    hz8_ctl u0 (
        .clk(clk), .rst_n(rst_n),
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .de_src_a(de_src_a), .de_src_b(de_src_b),
        .x1_dst(x1_dst), .x1_we(x1_we),
        .x2_dst(x2_dst), .x2_we(x2_we), .x2_ld(x2_ld),
        .m1_dst(m1_dst), .m1_we(m1_we), .m1_ld(m1_ld),
        .wb_dst(wb_dst), .wb_we(wb_we), .redirect(redirect),
        .front_hold(front_hold), .de_hold(de_hold), .bubble(bubble),
        .flush_fetch(flush_fetch), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    typedef struct packed {
        logic [7:0] ia, ib, da, db, x1d, x2d, m1d, wbd;
        logic x1w, x2w, x2l, m1w, m1l, wbw, rd;
    } stim_t;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;

    stim_t nx;
    exp_t  sq[$];
    int    checks = 0;
    int    bad = 0;
    bit    done = 1'b0;

    task automatic quiet();
        nx = '0;
        nx.ia = 8'hFF; nx.ib = 8'hFF; nx.da = 8'hFF; nx.db = 8'hFF;
    endtask

    task automatic put(input stim_t s);
        id_src_a = s.ia; id_src_b = s.ib; de_src_a = s.da; de_src_b = s.db;
        x1_dst = s.x1d; x1_we = s.x1w;
        x2_dst = s.x2d; x2_we = s.x2w; x2_ld = s.x2l;
        m1_dst = s.m1d; m1_we = s.m1w; m1_ld = s.m1l;
        wb_dst = s.wbd; wb_we = s.wbw; redirect = s.rd;
    endtask

    // Driver: apply staged inputs for one cycle and queue the expected outputs.
    task automatic cyc(input logic fh, input logic dh, input logic bb, input logic fl,
                       input logic [1:0] fa, input logic [1:0] fb, input string tag);
        @(negedge clk);
        put(nx);
        sq.push_back('{v: {fh, dh, bb, fl, fa, fb}, tag: tag});
    endtask

    // Monitor: compare outputs 2 ns after the driver changed inputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sq.size() > 0) begin
                exp_t e;
                logic [7:0] act;
                e = sq.pop_front();
                act = {front_hold, de_hold, bubble, flush_fetch, fwd_a, fwd_b};
                checks++;
                if (act !== e.v) begin
                    bad++;
                    $display("FAIL %s act=%b exp=%b (hold,dehold,bubble,flush,fa,fb)",
                             e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog all-reqs act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        quiet(); put(nx);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        quiet(); cyc(0,0,0,0,0,0, "R11 reset state");

        // R1 / R2 structural port
        quiet(); nx.ia = 8'd5; nx.wbd = 8'd9; nx.wbw = 1; cyc(1,0,0,0,0,0, "R1 wb vs id read");
        quiet(); nx.ib = 8'd0; nx.wbd = 8'd9; nx.wbw = 1; cyc(1,0,0,0,0,0, "R1 id reads r0");
        quiet(); nx.wbd = 8'd9; nx.wbw = 1; cyc(0,0,0,0,0,0, "R2 id no read");
        quiet(); nx.ia = 8'd5; nx.wbd = 8'd9; cyc(0,0,0,0,0,0, "R2 wb no write");
        quiet(); nx.ia = 8'd40; nx.wbd = 8'd9; nx.wbw = 1; cyc(0,0,0,0,0,0, "R7 id src unused");
        quiet(); nx.ia = 8'd3; nx.wbd = 8'd0; nx.wbw = 1; cyc(0,0,0,0,0,0, "R8 wb dst r0");

        // R3 EX1/EX2 writer
        quiet(); nx.db = 8'd7; nx.x1d = 8'd7; nx.x1w = 1; cyc(1,1,1,0,0,0, "R3 ex1 match");
        quiet(); nx.db = 8'd7; nx.x1d = 8'd7; cyc(0,0,0,0,0,0, "R3 ex1 no write");

        // R4 loads in flight
        quiet(); nx.da = 8'd4; nx.x2d = 8'd4; nx.x2w = 1; nx.x2l = 1; cyc(1,1,1,0,0,0, "R4 load x2");
        quiet(); nx.da = 8'd4; nx.m1d = 8'd4; nx.m1w = 1; nx.m1l = 1; cyc(1,1,1,0,0,0, "R4 load m1");
        quiet(); nx.da = 8'd4; nx.x2d = 8'd4; nx.x2w = 1; cyc(0,0,0,0,1,0, "R4 alu x2 fwd");
        quiet(); nx.da = 8'd4; nx.m1d = 8'd4; nx.m1w = 1; cyc(0,0,0,0,2,0, "R4 alu m1 fwd");
        quiet(); nx.da = 8'd4; nx.wbd = 8'd4; nx.wbw = 1; cyc(0,0,0,0,3,0, "R5 wb fwd");

        // R5 priority
        quiet(); nx.db = 8'd4; nx.x2d = 8'd4; nx.x2w = 1; nx.m1d = 8'd4; nx.m1w = 1;
        nx.wbd = 8'd4; nx.wbw = 1; cyc(0,0,0,0,0,1, "R5 three match");
        quiet(); nx.db = 8'd4; nx.m1d = 8'd4; nx.m1w = 1; nx.wbd = 8'd4; nx.wbw = 1;
        cyc(0,0,0,0,0,2, "R5 m1 over wb");
        quiet(); nx.da = 8'd4; nx.db = 8'd6; nx.x2d = 8'd4; nx.x2w = 1; nx.m1d = 8'd6; nx.m1w = 1;
        cyc(0,0,0,0,1,2, "R5 independent ops");

        // R6 load shadowing
        quiet(); nx.da = 8'd4; nx.x2d = 8'd4; nx.x2w = 1; nx.x2l = 1; nx.m1d = 8'd4; nx.m1w = 1;
        cyc(1,1,1,0,0,0, "R6 x2 load shadows m1");
        quiet(); nx.da = 8'd4; nx.m1d = 8'd4; nx.m1w = 1; nx.m1l = 1; nx.wbd = 8'd4; nx.wbw = 1;
        cyc(1,1,1,0,0,0, "R6 m1 load shadows wb");

        // R7 / R8 unused and zero registers
        quiet(); nx.da = 8'd37; nx.x1d = 8'd5; nx.x1w = 1; cyc(0,0,0,0,0,0, "R7 alias no stall");
        quiet(); nx.da = 8'd33; nx.x2d = 8'd33; nx.x2w = 1; cyc(0,0,0,0,0,0, "R7 out range fwd");
        quiet(); nx.da = 8'd0; nx.x1d = 8'd0; nx.x1w = 1; cyc(0,0,0,0,0,0, "R8 x1 r0");
        quiet(); nx.db = 8'd0; nx.x2d = 8'd0; nx.x2w = 1; nx.wbd = 8'd0; nx.wbw = 1;
        cyc(0,0,0,0,0,0, "R8 fwd r0");

        // R9 / R10 flush
        quiet(); nx.rd = 1; cyc(0,0,0,1,0,0, "R9 direct flush");
        quiet(); nx.rd = 1; nx.da = 8'd7; nx.x1d = 8'd7; nx.x1w = 1; cyc(1,1,1,0,0,0, "R10 held redirect");
        quiet(); cyc(0,0,0,1,0,0, "R10 deferred flush");
        quiet(); cyc(0,0,0,0,0,0, "R10 single pulse");
        quiet(); nx.rd = 1; nx.ia = 8'd2; nx.wbd = 8'd3; nx.wbw = 1; cyc(1,0,0,0,0,0, "R10 redirect in port hold");
        quiet(); nx.da = 8'd7; nx.x1d = 8'd7; nx.x1w = 1; cyc(1,1,1,0,0,0, "R10 still held");
        quiet(); cyc(0,0,0,1,0,0, "R10 release flush");
        quiet(); cyc(0,0,0,0,0,0, "R10 pulse cleared");

        // R11 reset clears pending redirect
        quiet(); nx.rd = 1; nx.da = 8'd7; nx.x1d = 8'd7; nx.x1w = 1; cyc(1,1,1,0,0,0, "R11 pend set");
        @(negedge clk);
        quiet(); put(nx);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        quiet(); cyc(0,0,0,0,0,0, "R11 pend cleared");

        @(negedge clk);
        #3;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule